// File: doc/BRIEF.md
# AXI4-Lite Byte-Offset Write Manager

This block turns a simple request (one byte address plus one data word) into a single AXI4-Lite write transaction. It drives the write-address, write-data and write-response channels, and it returns the subordinate's response code to the requester as a one-cycle completion pulse.

The byte strobes come from the low address bits. Byte lanes at or above the offset within the word are enabled, and lanes below it are disabled. The data word is never shifted to fit the offset. Disabled lanes are driven to zero on the data bus. The full byte address, including its low bits, goes out on the address channel.

Only one write is in flight at a time. The requester sees `cmd_ready` again only after the completion pulse.

Top module: `axil_wr_mgr`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `m_awvalid`, `m_wvalid`, `m_bready` and `done_valid` are 0.
- R2: A command accepted at a clock edge (`cmd_valid` and `cmd_ready` both 1) raises `m_awvalid` and `m_wvalid` together in the following cycle. `m_awaddr` equals the full `cmd_addr`.
- R3: `m_wstrb` bit i is 1 exactly when i ≥ `cmd_addr[1:0]`. This gives 1111 for offset 0, 1110 for 1, 1100 for 2 and 1000 for 3. Bit i covers data bits [8i+7:8i].
- R4: `m_wdata` keeps every enabled byte lane in its original position, not shifted. Each lane whose strobe bit is 0 is driven to 8'h00.
- R5: `m_awvalid` and `m_awaddr` stay unchanged while `m_awready` is 0. `m_awvalid` falls after exactly one handshake.
- R6: `m_wvalid`, `m_wdata` and `m_wstrb` stay unchanged while `m_wready` is 0. `m_wvalid` falls after exactly one handshake.
- R7: `m_bready` is 1 in every cycle from the cycle after acceptance until the response handshake, and 0 otherwise.
- R8: The cycle after the `m_bvalid`/`m_bready` handshake, `done_valid` is 1 for exactly one cycle. In that cycle `done_resp` equals the `m_bresp` that was sampled.
- R9: `cmd_ready` is 0 from the cycle after acceptance through the `done_valid` cycle, and it returns to 1 the cycle after. A `cmd_valid` asserted while busy is ignored: it starts no transaction.
- R10: The address and data handshakes complete independently, in either order. The response is awaited only after both have completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Manager idle, request can be taken |
| cmd_addr | input | ADDR_W | Byte address of the write |
| cmd_data | input | DATA_W | Unshifted write word |
| done_valid | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Response code of the completed write |
| m_awvalid | output | 1 | Write-address valid |
| m_awready | input | 1 | Write-address ready |
| m_awaddr | output | ADDR_W | Write byte address |
| m_wvalid | output | 1 | Write-data valid |
| m_wready | input | 1 | Write-data ready |
| m_wdata | output | DATA_W | Write data with disabled lanes zeroed |
| m_wstrb | output | DATA_W/8 | Byte-lane enables |
| m_bvalid | input | 1 | Write-response valid |
| m_bready | output | 1 | Write-response ready |
| m_bresp | input | 2 | Write-response code |

## Verification
The assertions take for granted that the subordinate behaves legally. It raises `m_bvalid` only after both the address and the data handshakes have completed, and it holds `m_bvalid` for one cycle at most once per write. The bench subordinate model follows this rule. It gives each channel its own ready delay, in random or directed order, and places the response one or more cycles after the later of the two handshakes. While a write is in flight, the bench also raises stray requests with junk payloads, so that the idle gating of `cmd_ready` is exercised.

// File: rtl/axil_wr_pkg.sv
// Package: shared state encoding and response width for the write manager.
// Assumes nothing beyond a single outstanding write.
package axil_wr_pkg;
    localparam int RESP_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } wr_state_e;
endpackage

// File: rtl/axil_lane_mask.sv
// Module: derives per-lane byte enables from the byte offset and zeroes the
// data of disabled lanes. Lanes at or above the offset are enabled; the data
// is not realigned. Assumes DATA_W is a multiple of 8 and at least 16.
module axil_lane_mask #(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [NB-1:0]     strb_o,
    output logic [DATA_W-1:0] data_o
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [OFF_W:0] LANE = (OFF_W+1)'(i);
        // Lane enable: set when this lane index is not below the offset.
        assign strb_o[i] = (LANE >= {1'b0, off_i});
        // Lane data: pass through when enabled, zero otherwise.
        assign data_o[i*8 +: 8] = strb_o[i] ? data_i[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/axil_chan_hold.sv
// Module: one valid/payload holding stage for an outgoing channel. Load sets
// valid and captures the payload; the handshake clears valid; the payload is
// held until the next load. Assumes load is never raised while valid is high.
module axil_chan_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] pay_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] pay_o
);
    // Valid flag: set on load, cleared on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_o <= 1'b0;
        else if (load_i)
            valid_o <= 1'b1;
        else if (ready_i)
            valid_o <= 1'b0;
    end

    // Payload register: captured only on load so it holds across stalls.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pay_o <= '0;
        else if (load_i)
            pay_o <= pay_i;
    end
endmodule

// File: rtl/axil_wr_ctrl.sv
// Module: transaction sequencer. It accepts a request when idle, waits for
// the write response, then raises a one-cycle done pulse carrying the
// response code. Assumes the subordinate answers only after both the
// address and data handshakes.
module axil_wr_ctrl
    import axil_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    output logic              accept_o,
    input  logic              bvalid_i,
    input  logic [RESP_W-1:0] bresp_i,
    output logic              bready_o,
    output logic              done_valid_o,
    output logic [RESP_W-1:0] done_resp_o
);
    wr_state_e state_q;
    wr_state_e state_d;
    logic      b_fire;

    assign cmd_ready_o  = (state_q == ST_IDLE);
    assign accept_o     = cmd_valid_i && cmd_ready_o;
    assign bready_o     = (state_q == ST_BUSY);
    assign done_valid_o = (state_q == ST_RESP);
    assign b_fire       = bvalid_i && bready_o;

    // Next-state selection for the single-outstanding sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept_o) state_d = ST_BUSY;
            ST_BUSY: if (b_fire)   state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Response capture at the response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_resp_o <= '0;
        else if (b_fire)
            done_resp_o <= bresp_i;
    end
endmodule

// File: rtl/axil_wr_mgr.sv
// Module: top of the AXI4-Lite write manager. It issues one address beat
// and one data beat per request, with byte enables taken from the address
// offset, and reports the response code. Assumes one request at a time.
module axil_wr_mgr
    import axil_wr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              done_valid,
    output logic [1:0]        done_resp,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);
    localparam int WP_W  = NB + DATA_W;

    logic              accept;
    logic [NB-1:0]     strb_n;
    logic [DATA_W-1:0] data_n;
    logic [WP_W-1:0]   w_pay;

    axil_wr_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid),
        .cmd_ready_o  (cmd_ready),
        .accept_o     (accept),
        .bvalid_i     (m_bvalid),
        .bresp_i      (m_bresp),
        .bready_o     (m_bready),
        .done_valid_o (done_valid),
        .done_resp_o  (done_resp)
    );

    axil_lane_mask #(.DATA_W(DATA_W)) mask_i (
        .off_i  (cmd_addr[OFF_W-1:0]),
        .data_i (cmd_data),
        .strb_o (strb_n),
        .data_o (data_n)
    );

    axil_chan_hold #(.W(ADDR_W)) aw_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .pay_i   (cmd_addr),
        .ready_i (m_awready),
        .valid_o (m_awvalid),
        .pay_o   (m_awaddr)
    );

    axil_chan_hold #(.W(WP_W)) w_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .pay_i   ({strb_n, data_n}),
        .ready_i (m_wready),
        .valid_o (m_wvalid),
        .pay_o   (w_pay)
    );

    assign m_wstrb = w_pay[WP_W-1 -: NB];
    assign m_wdata = w_pay[DATA_W-1:0];
endmodule

// File: rtl/axil_wr_mgr_chk.sv
// Module: property checker for the write manager, bound to the top. Assumes
// a legal subordinate (response only after both handshakes).
module axil_wr_mgr_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              done_valid,
    input logic [1:0]        done_resp,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [DATA_W-1:0] m_wdata,
    input logic [NB-1:0]     m_wstrb,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic [1:0]        m_bresp
);
    a_r2_aw_w_together: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (m_awvalid && m_wvalid));

    a_r3_strb_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> (m_wstrb == NB'(~((NB'(1) << m_awaddr[OFF_W-1:0]) - NB'(1)))));

    for (genvar i = 0; i < NB; i++) begin : g_zero
        a_r4_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (m_wvalid && !m_wstrb[i]) |-> (m_wdata[i*8 +: 8] == 8'h00));
    end

    a_r5_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    a_r5_aw_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && m_awready) |=> !m_awvalid);

    a_r6_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));

    a_r6_w_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready) |=> !m_wvalid);

    a_r7_bready_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid || m_wvalid) |-> m_bready);

    a_r8_done_after_b: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready) |=> (done_valid && done_resp == $past(m_bresp)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid || m_wvalid || m_bready || done_valid) |-> !cmd_ready);
endmodule

bind axil_wr_mgr axil_wr_mgr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .done_valid (done_valid),
    .done_resp  (done_resp),
    .m_awvalid  (m_awvalid),
    .m_awready  (m_awready),
    .m_awaddr   (m_awaddr),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready),
    .m_wdata    (m_wdata),
    .m_wstrb    (m_wstrb),
    .m_bvalid   (m_bvalid),
    .m_bready   (m_bready),
    .m_bresp    (m_bresp)
);

// File: tb/axil_wr_mgr_tb_top.sv
// Bench: directed and seeded-random writes against a subordinate model with
// independent channel delays; expected values come from bench functions.
`timescale 1ns/1ps
module axil_wr_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic        done_valid;
    logic [1:0]  done_resp;
    logic        m_awvalid;
    logic        m_awready = 1'b0;
    logic [15:0] m_awaddr;
    logic        m_wvalid;
    logic        m_wready = 1'b0;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic        m_bvalid = 1'b0;
    logic        m_bready;
    logic [1:0]  m_bresp = '0;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    always #10 clk = ~clk;

    axil_wr_mgr dut_i (.*);

    function automatic logic [3:0] exp_strb(input logic [1:0] off);
        case (off)
            2'd0: return 4'b1111;
            2'd1: return 4'b1110;
            2'd2: return 4'b1100;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input logic [1:0] off, input logic [31:0] d);
        logic [31:0] r = '0;
        logic [3:0]  s = exp_strb(off);
        for (int b = 0; b < 4; b++)
            if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] addr, input logic [31:0] data,
                            input int aw_dly, input int w_dly, input int b_dly,
                            input logic [1:0] resp);
        int bc;
        bc = ((aw_dly > w_dly) ? aw_dly : w_dly) + 1 + b_dly;
        @(negedge clk);
        chk("R9 ready when idle", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1;
        cmd_addr  = addr;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c <= bc; c++) begin
            if (c > 0) @(negedge clk);
            chk("R2/R5 awvalid", 64'(m_awvalid), 64'(c <= aw_dly));
            chk("R2/R6/R10 wvalid", 64'(m_wvalid), 64'(c <= w_dly));
            if (m_awvalid) chk("R2 awaddr", 64'(m_awaddr), 64'(addr));
            if (m_wvalid) begin
                chk("R3 wstrb", 64'(m_wstrb), 64'(exp_strb(addr[1:0])));
                chk("R4 wdata", 64'(m_wdata), 64'(exp_data(addr[1:0], data)));
            end
            chk("R7 bready", 64'(m_bready), 64'd1);
            chk("R9 busy not ready", 64'(cmd_ready), 64'd0);
            chk("R8 no early done", 64'(done_valid), 64'd0);
            m_awready = (c == aw_dly);
            m_wready  = (c == w_dly);
            m_bvalid  = (c == bc);
            m_bresp   = (c == bc) ? resp : 2'($urandom_range(0, 3));
            cmd_valid = (c < bc) ? 1'($urandom_range(0, 1)) : 1'b0;
            cmd_addr  = 16'($urandom);
            cmd_data  = $urandom;
        end
        @(negedge clk);
        m_awready = 1'b0;
        m_wready  = 1'b0;
        m_bvalid  = 1'b0;
        chk("R8 done pulse", 64'(done_valid), 64'd1);
        chk("R8 done resp", 64'(done_resp), 64'(resp));
        chk("R9 not ready in done", 64'(cmd_ready), 64'd0);
        chk("R7 bready low after", 64'(m_bready), 64'd0);
        @(negedge clk);
        chk("R8 pulse one cycle", 64'(done_valid), 64'd0);
        chk("R9 ready after done", 64'(cmd_ready), 64'd1);
        chk("R9 stray ignored aw", 64'(m_awvalid), 64'd0);
        chk("R9 stray ignored w", 64'(m_wvalid), 64'd0);
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R1 awvalid", 64'(m_awvalid), 64'd0);
        chk("R1 wvalid", 64'(m_wvalid), 64'd0);
        chk("R1 bready", 64'(m_bready), 64'd0);
        chk("R1 done_valid", 64'(done_valid), 64'd0);
        // R3 R4: every offset with zero stall
        for (int o = 0; o < 4; o++)
            do_write(16'h0100 + 16'(o), 32'hDEADBEEF, 0, 0, 0, 2'b00);
        // R10: data before address, then address before data
        do_write(16'h2002, 32'h12345678, 4, 0, 1, 2'b10);
        do_write(16'h0003, 32'hA5A55A5A, 0, 3, 0, 2'b11);
        do_write(16'hFFFD, 32'hCAFEF00D, 2, 2, 3, 2'b01);
        for (int k = 0; k < 40; k++)
            do_write(16'($urandom), $urandom, int'($urandom_range(0, 4)),
                     int'($urandom_range(0, 4)), int'($urandom_range(0, 3)),
                     2'($urandom_range(0, 3)));
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule